// File: doc/BRIEF.md
# Ternary Controlled Permutation Gate

This combinational gate works on three-valued signals, each carried as a 2-bit trit. It can apply one of five fixed permutations of {0,1,2} to a target trit. Whether the permutation fires depends on one or two control trits. The control trits always leave the gate unchanged. With a legal permutation code, every setting of the mode and the code therefore maps the 27 possible (control A, control B, target) triples one-to-one onto themselves, so the gate is reversible.

A 2-bit mode picks how the gate fires:
- Single-control mode fires when control A holds 2.
- Two-control mode fires when both controls equal their activating values. These values come from ports or, in a build-time variant, from parameters that default to (2,2).
- Dual-shift mode always outputs the target plus 2, modulo 3.
- Pass mode leaves the target untouched.

A separate helper path takes two permutation codes and returns, in the same cycle, the code of the single permutation that equals applying the first and then the second. This lets a netlist builder fold cascaded gates into one.

Illegal values are reported on an error flag. A trit of 2'b11 on any trit input turns every trit output into 2'b11. A permutation code outside the defined set acts as identity.

Top module: `tern_perm_gate`

## Requirements
- R1: Trits are encoded 2'b00=0, 2'b01=1, 2'b10=2. The permutation codes are 0=identity, 1=+1, 2=+2, 3=swap of 1 and 2, 4=swap of 0 and 1, 5=swap of 0 and 2. The +1 code maps 0→1, 1→2, 2→0, and the +2 code maps 0→2, 1→0, 2→1.
- R2: Code 3 maps 0→0, 1→2, 2→1. Code 4 maps 0→1, 1→0, 2→2. Code 5 maps 0→2, 1→1, 2→0.
- R3: In single-control mode (mode 2'b00), the selected permutation acts on the target only when control A equals 2. Control B and the activating values have no effect on the target.
- R4: In two-control mode (mode 2'b01), the permutation acts only when control A equals activating value A and control B equals activating value B. Any other combination passes the target unchanged.
- R5: In dual-shift mode (mode 2'b10), the target output is (target+2) mod 3, whatever the controls and the permutation code.
- R6: In pass mode (mode 2'b11), the target output equals the target input.
- R7: With all trit inputs legal, each control output equals its control input in every mode.
- R8: If control A, control B, the target or a used activating value is 2'b11, all three trit outputs are 2'b11 and the error flag is 1.
- R9: Permutation codes 6 and 7 act as identity and raise the error flag. With legal trits and codes 0 to 5, the error flag is 0.
- R10: The composition output gives the code (0 to 5) of the mapping "first code, then second code". For example: +1 then +1 gives 2, +1 then +2 gives 0, +1 then code 3 gives 5, and code 3 then code 3 gives 0. An input code of 6 or 7 counts as identity and raises the composition error flag.
- R11: With the parameter USE_MATCH_PORTS=0, the activating pair comes from parameters (default 2,2). The activating-value ports are then ignored, including the 2'b11 value.
- R12: For a fixed mode and a legal permutation code, the 27 legal input triples map to 27 distinct output triples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | 00 single-control, 01 two-control, 10 dual-shift, 11 pass |
| perm_sel_i | input | 3 | permutation code applied when the gate fires |
| ctl_a_i | input | 2 | control trit A |
| ctl_b_i | input | 2 | control trit B |
| tgt_i | input | 2 | target trit |
| match_a_i | input | 2 | activating value for control A (two-control mode) |
| match_b_i | input | 2 | activating value for control B (two-control mode) |
| cmp_first_i | input | 3 | first permutation code of a cascade |
| cmp_second_i | input | 3 | second permutation code of a cascade |
| ctl_a_o | output | 2 | control A passed through |
| ctl_b_o | output | 2 | control B passed through |
| tgt_o | output | 2 | target result |
| err_o | output | 1 | illegal trit or illegal permutation code on the gate path |
| cmp_code_o | output | 3 | code of the composed permutation |
| cmp_err_o | output | 1 | illegal code on the composition path |

## Verification
The gate path and the composition path are independent and are both evaluated in the same cycle. The bench therefore drives each gate case and a composition query at the same time, with unrelated codes, and checks that neither result leaks into the other. Two error sources can also coincide: an illegal trit and an illegal permutation code in the same cycle. For that case the bench expects all trit outputs to read 2'b11 with a single raised error flag. It also expects the composition flag to reflect only its own codes.

// File: rtl/tern_pkg.sv
package tern_pkg;

   localparam int TRIT_W = 2;
   localparam int CODE_W = 3;
   localparam logic [TRIT_W-1:0] TRIT_BAD = 2'b11;

   typedef enum logic [1:0] {
      MODE_ONE   = 2'b00,
      MODE_TWO   = 2'b01,
      MODE_SHIFT = 2'b10,
      MODE_PASS  = 2'b11
   } gate_mode_e;

   typedef enum logic [CODE_W-1:0] {
      PC_ID   = 3'd0,
      PC_INC  = 3'd1,
      PC_DEC  = 3'd2,
      PC_SW12 = 3'd3,
      PC_SW01 = 3'd4,
      PC_SW02 = 3'd5
   } perm_code_e;

   localparam logic [CODE_W-1:0] PC_LAST = 3'd5;

   // Image of one trit under a permutation code; undefined codes are identity.
   function automatic logic [TRIT_W-1:0] perm_apply(input logic [CODE_W-1:0] code,
                                                    input logic [TRIT_W-1:0] t);
      logic [TRIT_W-1:0] r;
      r = t;
      case (code)
         PC_INC:  r = (t == 2'd0) ? 2'd1 : (t == 2'd1) ? 2'd2 : 2'd0;
         PC_DEC:  r = (t == 2'd0) ? 2'd2 : (t == 2'd1) ? 2'd0 : 2'd1;
         PC_SW12: r = (t == 2'd1) ? 2'd2 : (t == 2'd2) ? 2'd1 : t;
         PC_SW01: r = (t == 2'd0) ? 2'd1 : (t == 2'd1) ? 2'd0 : t;
         PC_SW02: r = (t == 2'd0) ? 2'd2 : (t == 2'd2) ? 2'd0 : t;
         default: r = t;
      endcase
      return r;
   endfunction

   // Code of the permutation whose images of 0,1,2 are i0,i1,i2.
   function automatic logic [CODE_W-1:0] perm_encode(input logic [TRIT_W-1:0] i0,
                                                     input logic [TRIT_W-1:0] i1,
                                                     input logic [TRIT_W-1:0] i2);
      logic [CODE_W-1:0] c;
      case ({i0, i1, i2})
         6'b01_10_00: c = PC_INC;
         6'b10_00_01: c = PC_DEC;
         6'b00_10_01: c = PC_SW12;
         6'b01_00_10: c = PC_SW01;
         6'b10_01_00: c = PC_SW02;
         default:     c = PC_ID;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/tern_perm_unit.sv
module tern_perm_unit
   import tern_pkg::*;
#(
   parameter int TW = TRIT_W,
   parameter int CW = CODE_W
) (
   input  logic [CW-1:0] code_i,
   input  logic [TW-1:0] trit_i,
   output logic [TW-1:0] trit_o,
   output logic          code_bad_o
);
   localparam logic [CW-1:0] LAST_CODE = CW'(PC_LAST);

   always_comb begin
      trit_o     = perm_apply(code_i, trit_i);
      code_bad_o = (code_i > LAST_CODE);
   end
endmodule

// File: rtl/tern_ctrl_match.sv
module tern_ctrl_match
   import tern_pkg::*;
#(
   parameter int TW = TRIT_W,
   parameter bit USE_MATCH_PORTS = 1'b1,
   parameter logic [TW-1:0] MATCH_A_DEF = 2'd2,
   parameter logic [TW-1:0] MATCH_B_DEF = 2'd2,
   parameter logic [TW-1:0] SINGLE_MATCH = 2'd2
) (
   input  logic [1:0]    mode_i,
   input  logic [TW-1:0] ctl_a_i,
   input  logic [TW-1:0] ctl_b_i,
   input  logic [TW-1:0] match_a_i,
   input  logic [TW-1:0] match_b_i,
   output logic          fire_o,
   output logic          match_bad_o
);
   logic [TW-1:0] act_a;
   logic [TW-1:0] act_b;

   if (USE_MATCH_PORTS) begin : g_port_match
      assign act_a       = match_a_i;
      assign act_b       = match_b_i;
      assign match_bad_o = (match_a_i == TRIT_BAD) || (match_b_i == TRIT_BAD);
   end else begin : g_fixed_match
      logic unused_match;
      assign unused_match = ^{match_a_i, match_b_i};
      assign act_a        = MATCH_A_DEF;
      assign act_b        = MATCH_B_DEF;
      assign match_bad_o  = 1'b0;
   end

   always_comb begin
      case (mode_i)
         MODE_ONE: fire_o = (ctl_a_i == SINGLE_MATCH);
         MODE_TWO: fire_o = (ctl_a_i == act_a) && (ctl_b_i == act_b);
         default:  fire_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/tern_perm_compose.sv
module tern_perm_compose
   import tern_pkg::*;
#(
   parameter int TW = TRIT_W,
   parameter int CW = CODE_W
) (
   input  logic [CW-1:0] first_i,
   input  logic [CW-1:0] second_i,
   output logic [CW-1:0] code_o,
   output logic          bad_o
);
   localparam int NVAL = 3;
   localparam logic [CW-1:0] LAST_CODE = CW'(PC_LAST);

   logic [TW-1:0] img [NVAL];

   for (genvar k = 0; k < NVAL; k++) begin : g_img
      assign img[k] = perm_apply(second_i, perm_apply(first_i, TW'(k)));
   end

   assign code_o = perm_encode(img[0], img[1], img[2]);
   assign bad_o  = (first_i > LAST_CODE) || (second_i > LAST_CODE);
endmodule

// File: rtl/tern_perm_gate.sv
module tern_perm_gate
   import tern_pkg::*;
#(
   parameter int TW = TRIT_W,
   parameter int CW = CODE_W,
   parameter bit USE_MATCH_PORTS = 1'b1,
   parameter logic [TW-1:0] MATCH_A_DEF = 2'd2,
   parameter logic [TW-1:0] MATCH_B_DEF = 2'd2,
   parameter logic [TW-1:0] SINGLE_MATCH = 2'd2
) (
   input  logic [1:0]    mode_i,
   input  logic [CW-1:0] perm_sel_i,
   input  logic [TW-1:0] ctl_a_i,
   input  logic [TW-1:0] ctl_b_i,
   input  logic [TW-1:0] tgt_i,
   input  logic [TW-1:0] match_a_i,
   input  logic [TW-1:0] match_b_i,
   input  logic [CW-1:0] cmp_first_i,
   input  logic [CW-1:0] cmp_second_i,
   output logic [TW-1:0] ctl_a_o,
   output logic [TW-1:0] ctl_b_o,
   output logic [TW-1:0] tgt_o,
   output logic          err_o,
   output logic [CW-1:0] cmp_code_o,
   output logic          cmp_err_o
);
   if (TW != 2) begin : g_bad_tw
      $error("tern_perm_gate: TW must be 2");
   end
   if (CW != 3) begin : g_bad_cw
      $error("tern_perm_gate: CW must be 3");
   end
   if (SINGLE_MATCH == TRIT_BAD || MATCH_A_DEF == TRIT_BAD || MATCH_B_DEF == TRIT_BAD) begin : g_bad_def
      $error("tern_perm_gate: activating values must be legal trits");
   end

   logic          fire;
   logic          match_bad;
   logic [TW-1:0] permuted;
   logic [TW-1:0] shifted;
   logic          code_bad;
   logic          shift_unused_bad;
   logic          in_bad;
   logic [TW-1:0] tgt_next;

   tern_ctrl_match #(
      .TW(TW), .USE_MATCH_PORTS(USE_MATCH_PORTS),
      .MATCH_A_DEF(MATCH_A_DEF), .MATCH_B_DEF(MATCH_B_DEF),
      .SINGLE_MATCH(SINGLE_MATCH)
   ) u_match (
      .mode_i(mode_i), .ctl_a_i(ctl_a_i), .ctl_b_i(ctl_b_i),
      .match_a_i(match_a_i), .match_b_i(match_b_i),
      .fire_o(fire), .match_bad_o(match_bad)
   );

   tern_perm_unit #(.TW(TW), .CW(CW)) u_sel_perm (
      .code_i(perm_sel_i), .trit_i(tgt_i),
      .trit_o(permuted), .code_bad_o(code_bad)
   );

   tern_perm_unit #(.TW(TW), .CW(CW)) u_dual_shift (
      .code_i(CW'(PC_DEC)), .trit_i(tgt_i),
      .trit_o(shifted), .code_bad_o(shift_unused_bad)
   );

   tern_perm_compose #(.TW(TW), .CW(CW)) u_compose (
      .first_i(cmp_first_i), .second_i(cmp_second_i),
      .code_o(cmp_code_o), .bad_o(cmp_err_o)
   );

   assign in_bad = (ctl_a_i == TRIT_BAD) || (ctl_b_i == TRIT_BAD)
                || (tgt_i == TRIT_BAD) || match_bad;

   always_comb begin
      case (mode_i)
         MODE_ONE, MODE_TWO: tgt_next = fire ? permuted : tgt_i;
         MODE_SHIFT:         tgt_next = shifted;
         default:            tgt_next = tgt_i;
      endcase
   end

   assign ctl_a_o = in_bad ? TRIT_BAD : ctl_a_i;
   assign ctl_b_o = in_bad ? TRIT_BAD : ctl_b_i;
   assign tgt_o   = in_bad ? TRIT_BAD : tgt_next;
   assign err_o   = in_bad || code_bad;
endmodule

// File: rtl/tern_perm_gate_chk.sv
module tern_perm_gate_chk #(
   parameter bit USE_MATCH_PORTS = 1'b1
) (
   input logic [1:0] mode_i,
   input logic [2:0] perm_sel_i,
   input logic [1:0] ctl_a_i,
   input logic [1:0] ctl_b_i,
   input logic [1:0] tgt_i,
   input logic [1:0] match_a_i,
   input logic [1:0] match_b_i,
   input logic [2:0] cmp_first_i,
   input logic [2:0] cmp_second_i,
   input logic [1:0] ctl_a_o,
   input logic [1:0] ctl_b_o,
   input logic [1:0] tgt_o,
   input logic       err_o,
   input logic [2:0] cmp_code_o,
   input logic       cmp_err_o
);
   logic any_bad;
   always_comb begin
      any_bad = (ctl_a_i == 2'b11) || (ctl_b_i == 2'b11) || (tgt_i == 2'b11)
             || (USE_MATCH_PORTS && ((match_a_i == 2'b11) || (match_b_i == 2'b11)));
      p_legal_out_r1: assert (any_bad || tgt_o != 2'b11)
         else $error("legal inputs gave an illegal target");
      p_single_hold_r3: assert (any_bad || mode_i != 2'b00 || ctl_a_i == 2'd2 || tgt_o == tgt_i)
         else $error("single-control mode changed target without control A at 2");
      p_shift_r5: assert (any_bad || mode_i != 2'b10 || ((tgt_o + 2'd1 == tgt_i) || (tgt_i == 2'd0 && tgt_o == 2'd2)))
         else $error("dual-shift result wrong");
      p_pass_r6: assert (any_bad || mode_i != 2'b11 || tgt_o == tgt_i)
         else $error("pass mode changed target");
      p_ctrl_pass_r7: assert (any_bad || (ctl_a_o == ctl_a_i && ctl_b_o == ctl_b_i))
         else $error("control trit altered");
      p_illegal_r8: assert (!any_bad || (err_o && ctl_a_o == 2'b11 && ctl_b_o == 2'b11 && tgt_o == 2'b11))
         else $error("illegal trit not forwarded");
      p_badcode_r9: assert (perm_sel_i < 3'd6 || err_o)
         else $error("undefined permutation code not flagged");
      p_cmp_range_r10: assert (cmp_code_o <= 3'd5 && (cmp_err_o == (cmp_first_i > 3'd5 || cmp_second_i > 3'd5)))
         else $error("composition output out of range");
   end
endmodule

bind tern_perm_gate tern_perm_gate_chk #(.USE_MATCH_PORTS(USE_MATCH_PORTS)) u_chk (
   .mode_i(mode_i), .perm_sel_i(perm_sel_i), .ctl_a_i(ctl_a_i), .ctl_b_i(ctl_b_i),
   .tgt_i(tgt_i), .match_a_i(match_a_i), .match_b_i(match_b_i),
   .cmp_first_i(cmp_first_i), .cmp_second_i(cmp_second_i),
   .ctl_a_o(ctl_a_o), .ctl_b_o(ctl_b_o), .tgt_o(tgt_o), .err_o(err_o),
   .cmp_code_o(cmp_code_o), .cmp_err_o(cmp_err_o)
);

// File: tb/tern_perm_gate_test.sv
module tern_perm_gate_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [1:0] mode, ca, cb, tg, ma, mb, fma, fmb;
   logic [2:0] sel, c1, c2;
   logic [1:0] ca_o, cb_o, tg_o, fca_o, fcb_o, ftg_o;
   logic       err, cerr, ferr, fcerr;
   logic [2:0] ccode, fccode;

   int n_chk = 0;
   int n_fail = 0;

   tern_perm_gate uut (
      .mode_i(mode), .perm_sel_i(sel), .ctl_a_i(ca), .ctl_b_i(cb), .tgt_i(tg),
      .match_a_i(ma), .match_b_i(mb), .cmp_first_i(c1), .cmp_second_i(c2),
      .ctl_a_o(ca_o), .ctl_b_o(cb_o), .tgt_o(tg_o), .err_o(err),
      .cmp_code_o(ccode), .cmp_err_o(cerr));

   tern_perm_gate #(.USE_MATCH_PORTS(1'b0)) uut_fix (
      .mode_i(mode), .perm_sel_i(sel), .ctl_a_i(ca), .ctl_b_i(cb), .tgt_i(tg),
      .match_a_i(fma), .match_b_i(fmb), .cmp_first_i(c1), .cmp_second_i(c2),
      .ctl_a_o(fca_o), .ctl_b_o(fcb_o), .tgt_o(ftg_o), .err_o(ferr),
      .cmp_code_o(fccode), .cmp_err_o(fcerr));

   function automatic int mp(input int c, input int t);
      case (c)
         1: return (t + 1) % 3;
         2: return (t + 2) % 3;
         3: return (t == 0) ? 0 : 3 - t;
         4: return (t == 2) ? 2 : 1 - t;
         5: return 2 - t;
         default: return t;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input int m, input int s, input int a, input int b, input int t,
                        input int xa, input int xb);
      @(posedge clk);
      #1;
      mode = 2'(m); sel = 3'(s); ca = 2'(a); cb = 2'(b); tg = 2'(t);
      ma = 2'(xa); mb = 2'(xb);
      @(negedge clk);
   endtask

   task automatic t_reset;
      drive(0, 0, 0, 0, 0, 2, 2);
      chk(tg_o == 0 && ca_o == 0 && cb_o == 0 && !err && ccode == 0 && !cerr,
          "R1", "all-zero idle state", int'(tg_o), 0);
   endtask

   task automatic t_perm_table;
      for (int c = 0; c < 6; c++)
         for (int t = 0; t < 3; t++) begin
            drive(0, c, 2, 0, t, 0, 0);
            chk(int'(tg_o) == mp(c, t) && !err, (c <= 2) ? "R1" : "R2",
                $sformatf("code %0d target %0d", c, t), int'(tg_o), mp(c, t));
         end
   endtask

   task automatic t_single;
      for (int a = 0; a < 3; a++)
         for (int b = 0; b < 3; b++) begin
            drive(0, 1, a, b, 1, b, a);
            chk(int'(tg_o) == ((a == 2) ? 2 : 1), "R3",
                $sformatf("single ctl a=%0d b=%0d", a, b), int'(tg_o), (a == 2) ? 2 : 1);
         end
   endtask

   task automatic t_two;
      for (int a = 0; a < 3; a++)
         for (int b = 0; b < 3; b++) begin
            drive(1, 5, a, b, 0, 1, 0);
            chk(int'(tg_o) == ((a == 1 && b == 0) ? 2 : 0), "R4",
                $sformatf("two ctl a=%0d b=%0d", a, b), int'(tg_o), (a == 1 && b == 0) ? 2 : 0);
         end
      drive(1, 3, 2, 2, 1, 2, 2);
      chk(tg_o == 2, "R4", "activating pair (2,2)", int'(tg_o), 2);
   endtask

   task automatic t_shift;
      for (int t = 0; t < 3; t++) begin
         drive(2, t + 3, t, 2 - t, t, 0, 0);
         chk(int'(tg_o) == (t + 2) % 3, "R5", $sformatf("dual shift of %0d", t), int'(tg_o), (t + 2) % 3);
      end
   endtask

   task automatic t_pass;
      for (int t = 0; t < 3; t++) begin
         drive(3, 1, 2, 2, t, 2, 2);
         chk(int'(tg_o) == t, "R6", $sformatf("pass of %0d", t), int'(tg_o), t);
      end
   endtask

   task automatic t_ctrl;
      for (int m = 0; m < 4; m++) begin
         drive(m, 2, 2, 1, 0, 2, 1);
         chk(ca_o == 2 && cb_o == 1, "R7", $sformatf("controls in mode %0d", m),
             int'({ca_o, cb_o}), int'({2'd2, 2'd1}));
      end
   endtask

   task automatic t_illegal;
      drive(0, 1, 3, 0, 1, 2, 2);
      chk(ca_o == 3 && cb_o == 3 && tg_o == 3 && err, "R8", "bad control A", int'(tg_o), 3);
      drive(1, 1, 0, 0, 3, 0, 0);
      chk(ca_o == 3 && cb_o == 3 && tg_o == 3 && err, "R8", "bad target", int'(ca_o), 3);
      drive(3, 0, 1, 1, 1, 3, 1);
      chk(ca_o == 3 && tg_o == 3 && err, "R8", "bad activating value", int'(tg_o), 3);
   endtask

   task automatic t_badcode;
      for (int c = 6; c < 8; c++) begin
         drive(0, c, 2, 0, 1, 2, 2);
         chk(tg_o == 1 && err, "R9", $sformatf("code %0d identity+flag", c), int'(tg_o), 1);
      end
      drive(0, 5, 2, 0, 1, 2, 2);
      chk(!err, "R9", "legal code no flag", int'(err), 0);
   endtask

   task automatic t_compose;
      int ex_a [4] = '{1, 1, 1, 3};
      int ex_b [4] = '{1, 2, 3, 3};
      int ex_r [4] = '{2, 0, 5, 0};
      for (int i = 0; i < 4; i++) begin
         c1 = 3'(ex_a[i]); c2 = 3'(ex_b[i]);
         @(negedge clk);
         chk(int'(ccode) == ex_r[i] && !cerr, "R10", $sformatf("example %0d", i), int'(ccode), ex_r[i]);
      end
      for (int f = 0; f < 8; f++)
         for (int s = 0; s < 8; s++) begin
            int want = 0;
            for (int c = 0; c < 6; c++)
               if (mp(c, 0) == mp(s, mp(f, 0)) && mp(c, 1) == mp(s, mp(f, 1)) && mp(c, 2) == mp(s, mp(f, 2)))
                  want = c;
            c1 = 3'(f); c2 = 3'(s);
            @(negedge clk);
            chk(int'(ccode) == want && cerr == (f > 5 || s > 5), "R10",
                $sformatf("compose %0d then %0d", f, s), int'(ccode), want);
         end
   endtask

   task automatic t_concurrent;
      c1 = 3'd7; c2 = 3'd4;
      drive(0, 6, 3, 1, 1, 2, 2);
      chk(tg_o == 3 && err && ccode == 4 && cerr, "R8", "illegal trit with bad code and compose",
          int'(ccode), 4);
      c1 = 3'd2; c2 = 3'd2;
      drive(1, 1, 0, 0, 0, 0, 0);
      chk(tg_o == 1 && !err && ccode == 1 && !cerr, "R10", "gate fire with compose", int'(ccode), 1);
   endtask

   task automatic t_fixed;
      fma = 2'd0; fmb = 2'd0;
      drive(1, 1, 2, 2, 0, 0, 0);
      chk(ftg_o == 1 && !ferr, "R11", "fixed pair (2,2) fires", int'(ftg_o), 1);
      drive(1, 1, 0, 0, 0, 0, 0);
      chk(ftg_o == 0, "R11", "fixed pair ignores ports at (0,0)", int'(ftg_o), 0);
      fma = 2'd3; fmb = 2'd3;
      drive(1, 1, 2, 2, 0, 0, 0);
      chk(ftg_o == 1 && !ferr, "R11", "illegal activating port ignored", int'(ftg_o), 1);
   endtask

   task automatic t_bijective;
      int cfg_m [4] = '{0, 1, 2, 3};
      int cfg_s [4] = '{3, 1, 5, 2};
      for (int k = 0; k < 4; k++) begin
         bit [26:0] seen = '0;
         for (int i = 0; i < 27; i++) begin
            drive(cfg_m[k], cfg_s[k], i / 9, (i / 3) % 3, i % 3, 1, 2);
            if (ca_o != 3 && cb_o != 3 && tg_o != 3)
               seen[int'(ca_o) * 9 + int'(cb_o) * 3 + int'(tg_o)] = 1'b1;
         end
         chk($countones(seen) == 27, "R12", $sformatf("bijective mode %0d", cfg_m[k]),
             $countones(seen), 27);
      end
   endtask

   initial begin
      mode = '0; sel = '0; ca = '0; cb = '0; tg = '0; ma = 2'd2; mb = 2'd2;
      fma = '0; fmb = '0; c1 = '0; c2 = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_perm_table();
      t_single();
      t_two();
      t_shift();
      t_pass();
      t_ctrl();
      t_illegal();
      t_badcode();
      t_compose();
      t_concurrent();
      t_fixed();
      t_bijective();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule